// File: doc/BRIEF.md
# Single-Bus Accumulator Machine

This block is a very small programmable processor. It runs a fixed program held in a 16-word by 8-bit program memory, and that program is supplied as a parameter when the block is built. All internal transfers pass over one 8-bit bus. The bus connects a 4-bit program counter, a 4-bit memory address register, and 8-bit instruction, accumulator, B and output registers. An adder/subtractor combines the accumulator with B. A 12-bit control word, produced by a six-phase sequencer, selects on every cycle which single source drives the bus and which registers capture it.

Each instruction takes exactly six clock cycles. The first three phases fetch the instruction: the program counter goes to the address register, the memory word goes to the instruction register, and the program counter is incremented. The last three phases execute the instruction. The program counter wraps from 15 to 0, so a program without a halt instruction repeats forever. A halt instruction freezes the whole machine through a common clock enable until reset is applied. The only outputs are the output register and a halted flag, and both are registered.

Top module: `acc_machine`

## Requirements
- R1: While `rst` is high at a rising edge, the machine clears every register to zero and returns the sequencer to its first phase. After reset, `out_val` is 0, `halted` is 0, and the first instruction is fetched from address 0.
- R2: Every instruction occupies six clock cycles: three fetch phases, then three execute phases. The program counter advances by one, only in the third fetch phase, and wraps from 15 to 0. An OUT result appears on `out_val` after the fourth phase of its instruction, not earlier.
- R3: Instruction word layout. Bits 7:4 hold the opcode: load = 0000, add = 0001, subtract = 0010, output = 1110, halt = 1111. Bits 3:0 hold an operand address, which the load, add and subtract instructions use. When the instruction register drives the bus, it supplies only bits 3:0, zero-extended.
- R4: Load sets the accumulator to the program-memory word at the operand address.
- R5: Add sets the accumulator to accumulator + word, modulo 256. No carry is kept.
- R6: Subtract sets the accumulator to accumulator + two's complement of the word, modulo 256.
- R7: Output copies the accumulator into the output register and ignores bits 3:0. `out_val` changes only through this instruction or reset.
- R8: Halt raises `halted` at the end of the third phase of its instruction. From then on, no register changes until reset.
- R9: The opcodes 0011 to 1101 do nothing in their execute phases. The machine then fetches the next instruction.
- R10: At most one source drives the internal bus in any cycle.
- R11: A reset applied in the middle of a program restarts execution from address 0 with a cleared accumulator and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| out_val | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has stopped the machine |

## Verification
The assertions check four rules on every cycle: the bus has a single driver, the program counter moves only in the third phase, the output register holds still unless an output instruction is in the instruction register, and the machine stays frozen after a halt. They also check that add and subtract results wrap modulo 256 and that a reset cycle leaves the machine in its start state. The bench's scenarios are needed for the rest:
- the exact cycle in which an output appears;
- that the operand bits of output and halt are ignored;
- that unused opcodes are harmless;
- that a program wraps correctly past address 15 and restarts after a mid-run reset.

The bench checks these against an instruction-level model for one directed program and one pseudo-random program.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;

  localparam int OPC_W      = 4;
  localparam int NUM_PHASES = 6;
  localparam int NUM_SRC    = 5;

  // bus source indices (select bit positions)
  localparam int SRC_PC  = 0;
  localparam int SRC_MEM = 1;
  localparam int SRC_IR  = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_ALU = 4;

  // opcode encodings (upper field of the instruction word)
  localparam logic [OPC_W-1:0] OP_LDA = 4'h0;
  localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OP_SUB = 4'h2;
  localparam logic [OPC_W-1:0] OP_OUT = 4'hE;
  localparam logic [OPC_W-1:0] OP_HLT = 4'hF;

  // 12-bit control word: drivers (drv_*), loads (ld_*), counter step, ALU mode
  typedef struct packed {
    logic step_pc;
    logic drv_pc;
    logic ld_mar;
    logic drv_mem;
    logic ld_ir;
    logic drv_ir;
    logic ld_acc;
    logic drv_acc;
    logic alu_sub;
    logic drv_alu;
    logic ld_b;
    logic ld_out;
  } ctl_word_t;

endpackage

// File: rtl/acc_sequencer.sv
`timescale 1ns/1ps
module acc_sequencer
  import acc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [OPC_W-1:0]      opcode,
  output ctl_word_t             cw,
  output logic [NUM_PHASES-1:0] phase,
  output logic                  halted
);

  logic [NUM_PHASES-1:0] phase_q;
  logic                  halted_q;
  logic                  is_lda, is_add, is_sub, is_out, is_hlt;
  logic                  is_mem_ref, is_arith;
  logic                  hold;

  // opcode decode: a direct tap of the instruction register, no bus involved
  always_comb begin
    is_lda     = (opcode == OP_LDA);
    is_add     = (opcode == OP_ADD);
    is_sub     = (opcode == OP_SUB);
    is_out     = (opcode == OP_OUT);
    is_hlt     = (opcode == OP_HLT);
    is_mem_ref = is_lda | is_add | is_sub;
    is_arith   = is_add | is_sub;
  end

  // machine-wide clock enable: low once a halt opcode reaches the third phase
  assign hold = halted_q | (is_hlt & phase_q[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= NUM_PHASES'(1);
    end else if (!hold) begin
      phase_q <= {phase_q[NUM_PHASES-2:0], phase_q[NUM_PHASES-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
    end else if (is_hlt && phase_q[2]) begin
      halted_q <= 1'b1;
    end
  end

  // control word: sum of products of phase and decoded opcode
  always_comb begin
    cw = '0;
    if (!hold) begin
      cw.drv_pc  = phase_q[0];
      cw.ld_mar  = phase_q[0] | (phase_q[3] & is_mem_ref);
      cw.drv_mem = phase_q[1] | (phase_q[4] & is_mem_ref);
      cw.ld_ir   = phase_q[1];
      cw.step_pc = phase_q[2];
      cw.drv_ir  = phase_q[3] & is_mem_ref;
      cw.drv_acc = phase_q[3] & is_out;
      cw.ld_out  = phase_q[3] & is_out;
      cw.ld_acc  = (phase_q[4] & is_lda) | (phase_q[5] & is_arith);
      cw.ld_b    = phase_q[4] & is_arith;
      cw.drv_alu = phase_q[5] & is_arith;
      cw.alu_sub = phase_q[5] & is_sub;
    end
  end

  assign phase  = phase_q;
  assign halted = halted_q;

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              sub,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] rhs_mod;

  // subtract = add the one's complement plus a carry-in of one
  always_comb begin
    rhs_mod = sub ? ~rhs : rhs;
    result  = lhs + rhs_mod + DATA_W'(sub);
  end

endmodule

// File: rtl/acc_bus.sv
`timescale 1ns/1ps
module acc_bus #(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0]        sel,
  input  logic [NUM_SRC*DATA_W-1:0] src,
  output logic [DATA_W-1:0]         bus
);

  logic [DATA_W-1:0] gated [NUM_SRC];

  // AND-OR multiplexer in place of tri-state drivers
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    assign gated[i] = src[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      bus = bus | gated[i];
    end
  end

endmodule

// File: rtl/acc_progmem.sv
`timescale 1ns/1ps
module acc_progmem #(
  parameter int                          ADDR_W  = 4,
  parameter int                          DATA_W  = 8,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] CONTENT = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 2**ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = CONTENT[i*DATA_W +: DATA_W];
  end

  // asynchronous read from the address register
  assign rdata = words[addr];

endmodule

// File: rtl/acc_machine.sv
`timescale 1ns/1ps
module acc_machine
  import acc_pkg::*;
#(
  parameter int                            ADDR_W  = 4,
  parameter int                            DATA_W  = 8,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] PROGRAM = {
    8'h05, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h00, 8'h00, 8'hF0, 8'hE0, 8'h1E, 8'hE0, 8'h0F}
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] out_val,
  output logic              halted
);

  localparam int PAD_W = DATA_W - ADDR_W;

  ctl_word_t             cw;
  logic [NUM_PHASES-1:0] phase;
  logic                  halted_s;
  logic [ADDR_W-1:0]     pc_q, mar_q;
  logic [DATA_W-1:0]     ir_q, acc_q, b_q, out_q;
  logic [DATA_W-1:0]     bus, mem_data, alu_y;
  logic [NUM_SRC-1:0]    bus_sel;
  logic [NUM_SRC*DATA_W-1:0] bus_src;

  acc_sequencer u_seq (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[DATA_W-1 -: OPC_W]),
    .cw     (cw),
    .phase  (phase),
    .halted (halted_s)
  );

  acc_progmem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONTENT(PROGRAM)) u_mem (
    .addr  (mar_q),
    .rdata (mem_data)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .lhs    (acc_q),
    .rhs    (b_q),
    .sub    (cw.alu_sub),
    .result (alu_y)
  );

  always_comb begin
    bus_sel          = '0;
    bus_sel[SRC_PC]  = cw.drv_pc;
    bus_sel[SRC_MEM] = cw.drv_mem;
    bus_sel[SRC_IR]  = cw.drv_ir;
    bus_sel[SRC_ACC] = cw.drv_acc;
    bus_sel[SRC_ALU] = cw.drv_alu;
    bus_src                              = '0;
    bus_src[SRC_PC*DATA_W  +: DATA_W]    = {{PAD_W{1'b0}}, pc_q};
    bus_src[SRC_MEM*DATA_W +: DATA_W]    = mem_data;
    bus_src[SRC_IR*DATA_W  +: DATA_W]    = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
    bus_src[SRC_ACC*DATA_W +: DATA_W]    = acc_q;
    bus_src[SRC_ALU*DATA_W +: DATA_W]    = alu_y;
  end

  acc_bus #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_bus (
    .sel (bus_sel),
    .src (bus_src),
    .bus (bus)
  );

  always_ff @(posedge clk) begin
    if (rst)             pc_q <= '0;
    else if (cw.step_pc) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            mar_q <= '0;
    else if (cw.ld_mar) mar_q <= bus[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           ir_q <= '0;
    else if (cw.ld_ir) ir_q <= bus;
  end

  always_ff @(posedge clk) begin
    if (rst)            acc_q <= '0;
    else if (cw.ld_acc) acc_q <= bus;
  end

  always_ff @(posedge clk) begin
    if (rst)          b_q <= '0;
    else if (cw.ld_b) b_q <= bus;
  end

  always_ff @(posedge clk) begin
    if (rst)            out_q <= '0;
    else if (cw.ld_out) out_q <= bus;
  end

  assign out_val = out_q;
  assign halted  = halted_s;

endmodule

// File: rtl/acc_machine_chk.sv
`timescale 1ns/1ps
module acc_machine_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input ctl_word_t             cw,
  input logic [NUM_PHASES-1:0] phase,
  input logic [OPC_W-1:0]      ir_op,
  input logic [ADDR_W-1:0]     pc,
  input logic [DATA_W-1:0]     acc,
  input logic [DATA_W-1:0]     b,
  input logic [DATA_W-1:0]     out_val,
  input logic                  halted
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (out_val == '0 && !halted && phase == NUM_PHASES'(1) && pc == '0 && acc == '0)); // R1

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw.drv_pc, cw.drv_mem, cw.drv_ir, cw.drv_acc, cw.drv_alu})); // R10

  AST_PC_THIRD_PHASE: assert property (@(posedge clk) disable iff (rst)
    !phase[2] |=> $stable(pc)); // R2

  AST_OUT_ONLY_BY_OUT: assert property (@(posedge clk) disable iff (rst)
    (ir_op != OP_OUT) |=> $stable(out_val)); // R7

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase[5] && ir_op == OP_ADD && !halted) |=> acc == DATA_W'($past(acc) + $past(b))); // R5

  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase[5] && ir_op == OP_SUB && !halted) |=> acc == DATA_W'($past(acc) - $past(b))); // R6

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc) && $stable(out_val) && $stable(phase))); // R8

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> (ir_op == OP_HLT)); // R8

endmodule

bind acc_machine acc_machine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cw      (cw),
  .phase   (phase),
  .ir_op   (ir_q[DATA_W-1 -: 4]),
  .pc      (pc_q),
  .acc     (acc_q),
  .b       (b_q),
  .out_val (out_q),
  .halted  (halted_s)
);

// File: tb/sim_acc_machine.sv
`timescale 1ns/1ps
module sim_acc_machine;

  typedef struct packed {
    logic [3:0] pc;
    logic [7:0] acc;
    logic [7:0] outr;
    logic       hlt;
  } mst_t;

  // pseudo-random program: load/add/sub/output/unused opcode, never halt
  function automatic logic [127:0] gen_prog(input logic [31:0] seed);
    logic [127:0] p;
    logic [31:0]  x;
    logic [3:0]   op;
    p = '0;
    x = seed;
    for (int i = 0; i < 16; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      case (x[18:16] % 3'd5)
        3'd0:    op = 4'h0;
        3'd1:    op = 4'h1;
        3'd2:    op = 4'h2;
        3'd3:    op = 4'hE;
        default: op = 4'h6;
      endcase
      p[i*8 +: 8] = {op, x[11:8]};
    end
    return p;
  endfunction

  // word 15 first, word 0 last
  localparam logic [127:0] PROG0 = {
    8'h64, 8'hC8, 8'hFF, 8'h90, 8'h00, 8'h00, 8'h00, 8'hF3,
    8'hE0, 8'h1C, 8'h7A, 8'hE5, 8'h2D, 8'hE0, 8'h1F, 8'h0E};
  localparam logic [127:0] PROG1 = gen_prog(32'h1234_5678);

  logic       clk  = 1'b0;
  logic       rst0 = 1'b1;
  logic       rst1 = 1'b1;
  logic [7:0] out0, out1;
  logic       hlt0, hlt1;
  int         nchk = 0;
  int         nfail = 0;
  bit         done = 1'b0;
  mst_t       m0, m1;

  always #2 clk = ~clk;

  acc_machine #(.PROGRAM(PROG0)) u0 (.clk(clk), .rst(rst0), .out_val(out0), .halted(hlt0));
  acc_machine #(.PROGRAM(PROG1)) u1 (.clk(clk), .rst(rst1), .out_val(out1), .halted(hlt1));

  // instruction-level reference model
  function automatic mst_t mstep(input logic [127:0] rom, input mst_t s);
    mst_t       n;
    logic [7:0] ins, d;
    n = s;
    if (s.hlt) return s;
    ins = rom[{s.pc, 3'b000} +: 8];
    d   = rom[{ins[3:0], 3'b000} +: 8];
    case (ins[7:4])
      4'h0: n.acc  = d;
      4'h1: n.acc  = s.acc + d;
      4'h2: n.acc  = s.acc - d;
      4'hE: n.outr = s.acc;
      4'hF: n.hlt  = 1'b1;
      default: ;
    endcase
    if (ins[7:4] != 4'hF) n.pc = s.pc + 4'd1;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic run0(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      repeat (6) @(negedge clk);
      m0 = mstep(PROG0, m0);
      chk(tag, out0, m0.outr);
      chk(tag, {7'b0, hlt0}, {7'b0, m0.hlt});
    end
  endtask

  task automatic run1(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      repeat (6) @(negedge clk);
      m1 = mstep(PROG1, m1);
      chk(tag, out1, m1.outr);
      chk(tag, {7'b0, hlt1}, {7'b0, m1.hlt});
    end
  endtask

  initial begin
    int k;
    void'($urandom(32'd20240607));
    m0 = '0;
    m1 = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out", out0, 8'h00);
    chk("R1 reset halted", {7'b0, hlt0}, 8'h00);
    rst0 = 1'b0;

    run0(2, "R4 R5 directed");
    repeat (3) @(negedge clk);
    chk("R2 output not before fourth phase", out0, 8'h00);
    @(negedge clk);
    chk("R5 R7 wrapped sum output", out0, 8'h2C);
    repeat (2) @(negedge clk);
    m0 = mstep(PROG0, m0);
    run0(2, "R6 directed");
    chk("R6 R3 subtract wrap, output operand ignored", out0, 8'h2D);
    run0(3, "R9 directed");
    chk("R9 R4 unused opcode harmless", out0, 8'hBD);

    repeat (2) @(negedge clk);
    chk("R8 halted low before third phase", {7'b0, hlt0}, 8'h00);
    @(negedge clk);
    chk("R8 halted after third phase", {7'b0, hlt0}, 8'h01);
    repeat (30) @(negedge clk);
    chk("R8 output frozen", out0, 8'hBD);
    chk("R8 halted held", {7'b0, hlt0}, 8'h01);

    rst0 = 1'b1;
    @(negedge clk);
    chk("R1 R11 reset from halt out", out0, 8'h00);
    chk("R1 R11 reset from halt flag", {7'b0, hlt0}, 8'h00);
    rst0 = 1'b0;
    m0 = '0;
    run0(3, "R11 restart");
    chk("R11 restart result", out0, 8'h2C);

    // random program on the second machine, reset at a random instruction
    rst1 = 1'b0;
    k = 10 + int'($urandom % 15);
    run1(k, "R2 R3 random program");
    rst1 = 1'b1;
    @(negedge clk);
    chk("R11 mid-run reset out", out1, 8'h00);
    chk("R11 mid-run reset flag", {7'b0, hlt1}, 8'h00);
    rst1 = 1'b0;
    m1 = '0;
    run1(40, "R2 R11 random program after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R2: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule